// File: doc/BRIEF.md
# Latched Interrupt Request Aggregator

This block gathers a bank of external interrupt request lines into one level-sensitive request for a parent interrupt controller. Each incoming line passes through a two-stage synchroniser and is then held in a sticky pending latch. A latch stays set after its line drops, until software clears it.

Software reaches three 32-bit registers through a small slave port. The port has a byte address, a write enable, write data and registered read data. A mask register blocks individual sources, with a one meaning blocked. A status register reports the pending sources that are not blocked. A clear register is written to one and then back to zero to retire a pending bit.

While a clear bit is one, the matching latch is held at zero. After the clear bit returns to zero, the latch sets again if the line is still high. Software reads the status word, handles the set bits from the lowest index upward, and pulses the clear bit of each one after handling it.

Top module: `irq_aggregator`

## Requirements
- R1: There are 32 sources, and source n maps to bit n of the input bus and of every register.
- R2: Register byte offsets are: clear at 0x10, mask at 0x14, status at 0x1C. A write takes effect at the clock edge where the write enable is sampled. Read data is returned on the edge after the address is presented.
- R3: After reset, every pending and clear bit is 0, every mask bit is 1, and irq_out is 0.
- R4: A mask bit of 1 keeps its source out of the status word and out of irq_out, but the source still latches as pending. Clearing the mask bit to 0 then exposes that pending bit.
- R5: A pending bit sets on any edge where its synchronised line is high and its clear bit is 0. It stays set after the line falls.
- R6: While a clear bit is 1, its pending bit is held at 0 even if the line is high. Once the clear bit returns to 0, the pending bit sets again if the line is still high.
- R7: The clear register keeps the value written to it and reads it back.
- R8: A status read returns pending AND NOT mask. Writes to the status offset change nothing.
- R9: irq_out is a register holding the OR of the status bits. It stays high until every unmasked pending bit is cleared or masked.
- R10: Reads of any other offset return 0. Writes to any other offset change nothing.
- R11: A line that rises just before edge E reaches the pending latch at edge E+2 and irq_out at edge E+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Asynchronous interrupt request lines, one per source |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined level interrupt request to the parent |

## Verification
A raised line takes three edges to reach the pending latch: two synchroniser flops and the latch itself. It takes one more edge to reach irq_out. The latency test therefore samples irq_out at the falling edge after the third rising edge, where it must still be low, and after the fourth, where it must be high. Register reads set the address at a falling edge and sample the data at the next falling edge, one registered stage later. In the table-driven cases, a status read is made only after five idle cycles, so all pipeline stages have settled. Clear pulses are issued only after the lines have been low for three cycles, so the synchroniser is empty when the latches are released.

// File: rtl/irqagg_pkg.sv
// Package: shared sizes and register offsets for the interrupt aggregator.
// Assumes byte addressing with 32-bit registers at word-aligned offsets.
package irqagg_pkg;
    localparam int N_SRC  = 32;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h1C;

    localparam logic [N_SRC-1:0] MASK_RESET = '1;
endpackage

// File: rtl/irqagg_sync.sv
// Module: multi-bit synchroniser chain.
// Each line is sampled through STAGES flops. Lines are independent, so the
// relative skew between them is not a concern.
module irqagg_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw lines through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_pending.sv
// Module: bank of sticky pending latches, one per source.
// A latch sets when its synchronised line is high. It is held at zero while
// its clear bit is one.
module irqagg_pending #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_s,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;

    // Per-source next state: set by the line, forced low by the clear bit.
    for (genvar i = 0; i < N; i++) begin : g_src
        assign pend_d[i] = (pend_q[i] | line_s[i]) & ~clr[i];
    end

    // Register the pending bank.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R6: a held clear bit leaves its pending bit at zero on the next edge
    a_r6_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((pend_q & $past(clr)) == '0));

    // R5: a high line with a zero clear bit sets the pending bit
    a_r5_line_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_s & ~clr) != '0) |=> ((pend_q & $past(line_s & ~clr)) == $past(line_s & ~clr)));

    // R5: a pending bit falls only when its clear bit was one
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & ~$past(clr) & ~pend_q) == '0));
endmodule

// File: rtl/irqagg_regs.sv
// Module: register file for clear, mask and status, with a registered read.
// Assumes one access per cycle. A read happens on every cycle at bus_addr.
module irqagg_regs
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N_SRC-1:0]  pend,
    output logic [N_SRC-1:0]  clr,
    output logic [N_SRC-1:0]  mask,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [N_SRC-1:0]  clr_q;
    logic [N_SRC-1:0]  mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;

    // Writable registers: clear and mask. Status and other offsets are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q  <= '0;
            mask_q <= MASK_RESET;
        end else if (bus_we) begin
            if (bus_addr == OFS_CLEAR) clr_q  <= bus_wdata[N_SRC-1:0];
            if (bus_addr == OFS_MASK)  mask_q <= bus_wdata[N_SRC-1:0];
        end
    end

    // Read selection by offset. Unmapped offsets read as zero.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CLEAR:  rd_mux[N_SRC-1:0] = clr_q;
            OFS_MASK:   rd_mux[N_SRC-1:0] = mask_q;
            OFS_STATUS: rd_mux[N_SRC-1:0] = pend & ~mask_q;
            default:    rd_mux = '0;
        endcase
    end

    // Register the read data, so it appears one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    assign clr       = clr_q;
    assign mask      = mask_q;
    assign bus_rdata = rdata_q;

    // R8: a write to the status offset changes neither writable register
    a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_STATUS) |=> ($stable(clr_q) && $stable(mask_q)));

    // R10: a write to an unmapped offset changes nothing
    a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != OFS_CLEAR && bus_addr != OFS_MASK)
        |=> ($stable(clr_q) && $stable(mask_q)));

    // R10: a read of an unmapped offset returns zero on the next cycle
    a_r10_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_CLEAR && bus_addr != OFS_MASK && bus_addr != OFS_STATUS)
        |=> (bus_rdata == '0));
endmodule

// File: rtl/irq_aggregator.sv
// Module: top level of the latched interrupt aggregator.
// Path: synchroniser, then pending latches, then mask, then registered OR to the parent.
// Assumes the parent treats irq_out as a level request.
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [N_SRC-1:0] line_s;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] mask;
    logic             irq_q;

    irqagg_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_lines), .dout(line_s)
    );

    irqagg_pending #(.N(N_SRC)) i_pend (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .clr(clr), .pend(pend)
    );

    irqagg_regs i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .pend(pend), .clr(clr), .mask(mask),
        .bus_rdata(bus_rdata)
    );

    // Register the combined request from the unmasked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & ~mask);
    end

    assign irq_out = irq_q;

    // R9: any unmasked pending bit raises irq_out on the next edge
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) != '0) |=> irq_out);

    // R4: with nothing unmasked pending, irq_out is low on the next edge
    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |=> !irq_out);
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [7:0] A_CLR = 8'h10, A_MSK = 8'h14, A_STS = 8'h1C;

    typedef struct packed {
        logic [31:0] lines;
        logic [31:0] mask;
        logic [31:0] exp_sts;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 1'b1},
        '{32'hA5A5_5A5A, 32'h0F0F_0F0F, 32'hA0A0_5050, 1'b1},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}
    };

    always #2.5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_CLR, 32'h0000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R3: reset state
        check32("R3 irq_out", {31'b0, irq_out}, 32'h0);
        rd(A_MSK, d); check32("R3 mask", d, 32'hFFFF_FFFF);
        rd(A_CLR, d); check32("R3 clear", d, 32'h0);
        rd(A_STS, d); check32("R3 status", d, 32'h0);
        rd(8'h00, d); check32("R10 unmapped read", d, 32'h0);

        // R1 R4 R8 R9: table-driven status and combined output
        for (int v = 0; v < NV; v++) begin
            wr(A_MSK, VECS[v].mask);
            irq_lines = VECS[v].lines;
            idle(5);
            rd(A_STS, d);
            check32("R8 status vector", d, VECS[v].exp_sts);
            check32("R9 irq_out vector", {31'b0, irq_out}, {31'b0, VECS[v].exp_irq});
            irq_lines = '0;
            idle(3);
            clear_all();
            idle(2);
        end

        // R11: latency from line to irq_out
        wr(A_MSK, 32'h0);
        @(negedge clk); irq_lines = 32'h0000_0020;
        idle(3); check32("R11 irq low after 3 edges", {31'b0, irq_out}, 32'h0);
        idle(1); check32("R11 irq high after 4 edges", {31'b0, irq_out}, 32'h1);

        // R5: sticky after the line falls
        irq_lines = '0;
        idle(5);
        rd(A_STS, d); check32("R5 sticky", d, 32'h0000_0020);
        check32("R9 irq held", {31'b0, irq_out}, 32'h1);

        // R6 R7: a held clear keeps the latch low while the line is high, then it re-sets
        irq_lines = 32'h0000_0020;
        wr(A_CLR, 32'h0000_0020);
        idle(5);
        rd(A_CLR, d); check32("R7 clear readback", d, 32'h0000_0020);
        rd(A_STS, d); check32("R6 held clear", d, 32'h0);
        check32("R9 irq dropped", {31'b0, irq_out}, 32'h0);
        wr(A_CLR, 32'h0);
        idle(3);
        rd(A_STS, d); check32("R6 re-set after release", d, 32'h0000_0020);
        irq_lines = '0;
        idle(3);
        clear_all();
        idle(2);

        // R4: a masked source still latches and shows once unmasked
        wr(A_MSK, 32'h0000_0100);
        irq_lines = 32'h0000_0100;
        idle(2); irq_lines = '0;
        idle(5);
        rd(A_STS, d); check32("R4 masked hidden", d, 32'h0);
        check32("R4 masked irq", {31'b0, irq_out}, 32'h0);
        wr(A_MSK, 32'h0);
        idle(2);
        rd(A_STS, d); check32("R4 unmask exposes", d, 32'h0000_0100);
        check32("R4 irq after unmask", {31'b0, irq_out}, 32'h1);

        // R8 R10: writes to status and unmapped offsets change nothing
        wr(A_STS, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(A_MSK, d); check32("R10 mask unchanged", d, 32'h0);
        rd(A_CLR, d); check32("R8 clear unchanged", d, 32'h0);
        rd(A_STS, d); check32("R8 status unchanged", d, 32'h0000_0100);
        rd(8'h18, d); check32("R10 unmapped read 0x18", d, 32'h0);

        // R2: a write lands on its own edge and reads back one cycle later
        @(negedge clk);
        bus_addr = A_MSK; bus_wdata = 32'h5555_AAAA; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        check32("R2 read after write", bus_rdata, 32'h5555_AAAA);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule